// File: doc/BRIEF.md
# I2C Slave Controller with Clock-Stretching Service Flags

This block is a 7-bit-address I2C slave that software drives through three small registers. It watches the SCL and SDA lines through synchronizers and finds START and STOP conditions. It matches the address byte against a programmable own address and then either receives or transmits data bytes. The lines are open-drain: the block never drives a line high, it only asks for a line to be pulled low through `scl_oe` and `sda_oe`.

Every byte is handed over to or taken from software one at a time. After each received byte, SCL is held low until software reads the byte. When the slave is addressed for a read, and again after every byte the master acknowledges, SCL is held low until software supplies the next byte. Three status flags tell software which service is due. One of them marks the first data byte after an address match, so software can split a register pointer from the data that follows it.

Register accesses are single-cycle strobes. Read data is combinational from `reg_addr`. A side effect of an access (clearing a flag, loading a byte, changing the enable) happens at the clock edge that ends the strobe cycle.

Top module: `i2c_stretch_slave`

## Requirements
- R1: After reset the status reads 0, the slave is disabled, neither `scl_oe` nor `sda_oe` is asserted, and the own-address register reads its reset value 7'h2A.
- R2: The register at offset 0 reads status as follows: bit 0 is the receive request, bit 1 is the transmit request, bit 2 is the first-byte flag, and every higher bit is 0. Writing offset 0 sets the enable from bit 0. Offset 1 is the data register, with the byte in bits 7:0. Offset 2 is the own address, bits 6:0, read/write.
- R3: An address byte whose upper 7 bits equal the own address is acknowledged by pulling SDA low during the ninth clock. On a mismatch no ACK is given, and the slave ACKs nothing and raises no flag until the next START.
- R4: In a write transfer each data byte is captured MSB first. The receive request rises, the byte reads back from offset 1, and the slave ACKs the byte.
- R5: While the receive request is set, SCL is held low. Reading offset 1 clears the request and releases SCL.
- R6: The first-byte flag is set together with the receive request only for the first data byte after an address match, and it clears when offset 1 is read.
- R7: An address match with the read bit (bit 0 = 1) raises the transmit request and holds SCL low. Writing offset 1 clears the request, releases SCL, and the byte is shifted out MSB first.
- R8: If the master ACKs a transmitted byte, the transmit request rises again. If the master NACKs it, the request stays clear and SDA is left released for the following clocks.
- R9: The first-byte flag never rises during a read (slave-transmit) transfer.
- R10: A START, repeated or not, restarts address reception mid-byte, and a STOP abandons the transfer. The next data byte after a new match is flagged as the first byte again.
- R11: Clearing the enable releases both lines and clears all three flags. While disabled, no address is acknowledged.
- R12: Reading offset 1 with no receive request pending, or writing it with no transmit request pending, changes no flag and drives no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | REG_DW | Register write data |
| reg_rdata | output | REG_DW | Register read data (combinational) |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
A line edge reaches the byte engine after the two synchronizer flops and the edge register. A flag or SDA change therefore follows an SCL falling edge by about four system clocks. The bench waits ten clocks, half a bit, after every SCL transition before it samples a line or reads status. A register access clears or loads at the edge that closes the strobe, so the bench checks its effect in a following access or on the line. Clearing the enable costs one cycle in the control register and one in the engine, so the bench waits two cycles before it checks the released lines.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

   // Register offsets. Software depends on these values.
   localparam logic [1:0] OFS_CTRL  = 2'd0;
   localparam logic [1:0] OFS_DATA  = 2'd1;
   localparam logic [1:0] OFS_OADDR = 2'd2;

   // Position of each request flag in the status word
   localparam int STAT_RX_BIT    = 0;
   localparam int STAT_TX_BIT    = 1;
   localparam int STAT_FIRST_BIT = 2;

   typedef enum logic [3:0] {
      ST_IDLE,    // no transfer or disabled
      ST_ADDR,    // shifting the address byte
      ST_AACK,    // driving the address ACK
      ST_RX,      // shifting a data byte in
      ST_RXACK,   // driving the data ACK, SCL held while unread
      ST_TXW,     // holding SCL until software supplies a byte
      ST_TX,      // shifting a byte out
      ST_TXACK,   // sampling the master ACK/NACK
      ST_SKIP     // not addressed, wait for START/STOP
   } slv_state_t;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
   parameter int          STAGES  = 2,
   parameter int          W       = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/i2cs_cond_det.sv
module i2cs_cond_det (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);

   logic scl_q, sda_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   // SDA moving while SCL stays high marks a bus condition
   assign bus_start =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign bus_stop  =  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
   import i2cs_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                active,
   input  logic [ADDR_W-1:0]   own_addr,
   input  logic                sda_s,
   input  logic                scl_rise,
   input  logic                scl_fall,
   input  logic                bus_start,
   input  logic                bus_stop,
   input  logic                rd_data,
   input  logic                wr_data,
   input  logic [ADDR_W:0]     tx_byte,
   output logic [ADDR_W:0]     rx_byte,
   output logic                rreq,
   output logic                treq,
   output logic                fbr,
   output logic                scl_oe,
   output logic                sda_oe
);

   localparam int BYTE_W = ADDR_W + 1;
   localparam int CNT_W  = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   slv_state_t        state;
   logic [BYTE_W-1:0] sreg;
   logic [BYTE_W-1:0] tsreg;
   logic [CNT_W-1:0]  bitcnt;
   logic              rw_q;
   logic              first_q;
   logic              nack_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         sreg    <= '0;
         tsreg   <= '0;
         bitcnt  <= '0;
         rw_q    <= 1'b0;
         first_q <= 1'b0;
         nack_q  <= 1'b0;
         rx_byte <= '0;
         rreq    <= 1'b0;
         treq    <= 1'b0;
         fbr     <= 1'b0;
         sda_oe  <= 1'b0;
      end else if (!active) begin
         state   <= ST_IDLE;
         bitcnt  <= '0;
         first_q <= 1'b0;
         rreq    <= 1'b0;
         treq    <= 1'b0;
         fbr     <= 1'b0;
         sda_oe  <= 1'b0;
      end else begin
         if (rd_data && rreq) begin
            rreq <= 1'b0;
            fbr  <= 1'b0;
         end
         if (bus_start) begin
            state   <= ST_ADDR;
            bitcnt  <= '0;
            first_q <= 1'b1;
            sda_oe  <= 1'b0;
         end else if (bus_stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR: begin
                  if (scl_rise) begin
                     sreg   <= {sreg[BYTE_W-2:0], sda_s};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == FULL) begin
                     bitcnt <= '0;
                     if (sreg[BYTE_W-1:1] == own_addr) begin
                        sda_oe <= 1'b1;
                        rw_q   <= sreg[0];
                        state  <= ST_AACK;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     if (rw_q) begin
                        treq  <= 1'b1;
                        state <= ST_TXW;
                     end else begin
                        state <= ST_RX;
                     end
                  end
               end
               ST_RX: begin
                  if (scl_rise) begin
                     sreg   <= {sreg[BYTE_W-2:0], sda_s};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == FULL) begin
                     bitcnt  <= '0;
                     rx_byte <= sreg;
                     rreq    <= 1'b1;
                     fbr     <= first_q;
                     first_q <= 1'b0;
                     sda_oe  <= 1'b1;
                     state   <= ST_RXACK;
                  end
               end
               ST_RXACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     state  <= ST_RX;
                  end
               end
               ST_TXW: begin
                  if (wr_data) begin
                     tsreg  <= tx_byte;
                     sda_oe <= ~tx_byte[BYTE_W-1];
                     treq   <= 1'b0;
                     bitcnt <= '0;
                     state  <= ST_TX;
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bitcnt == FULL) begin
                        sda_oe <= 1'b0;
                        state  <= ST_TXACK;
                     end else begin
                        tsreg  <= {tsreg[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~tsreg[BYTE_W-2];
                     end
                  end
               end
               ST_TXACK: begin
                  if (scl_rise) begin
                     nack_q <= sda_s;
                  end else if (scl_fall) begin
                     if (!nack_q) begin
                        treq  <= 1'b1;
                        state <= ST_TXW;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // Hold SCL low while a byte waits on software in either direction
   assign scl_oe = (state == ST_RXACK && rreq) || (state == ST_TXW);

   AST_RX_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
      rreq |-> scl_oe) else $error("SCL not held with receive pending"); // R5
   AST_RD_CLEARS_RREQ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && rreq) |=> !rreq) else $error("read did not clear rreq"); // R5
   AST_TX_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
      treq |-> scl_oe) else $error("SCL not held with transmit pending"); // R7
   AST_WR_CLEARS_TREQ: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && treq) |=> !treq) else $error("write did not clear treq"); // R7
   AST_FBR_NEEDS_RREQ: assert property (@(posedge clk) disable iff (!rst_n)
      fbr |-> rreq) else $error("first-byte flag without receive request"); // R6
   AST_NO_FBR_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
      treq |-> !fbr) else $error("first-byte flag during transmit"); // R9
   AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (!scl_oe && !sda_oe && !rreq && !treq)) else $error("disabled slave still busy"); // R11

endmodule

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave
   import i2cs_pkg::*;
#(
   parameter int          REG_DW       = 32,
   parameter int          ADDR_W       = 7,
   parameter int          SYNC_STAGES  = 2,
   parameter logic [6:0]  OWN_ADDR_RST = 7'h2A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe
);

   localparam int BYTE_W = ADDR_W + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_W != 7) begin : g_chk_addr
         $error("only 7-bit addressing is supported");
      end
      if (REG_DW <= BYTE_W) begin : g_chk_dw
         $error("REG_DW must exceed the byte width");
      end
   endgenerate

   logic              active;
   logic [ADDR_W-1:0] own_addr;
   logic [1:0]        line_s;
   logic              scl_rise, scl_fall, bus_start, bus_stop;
   logic              rd_data, wr_data;
   logic [BYTE_W-1:0] rx_byte;
   logic              rreq, treq, fbr;
   logic              unused_wdata_hi;

   assign unused_wdata_hi = ^reg_wdata[REG_DW-1:BYTE_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active   <= 1'b0;
         own_addr <= ADDR_W'(OWN_ADDR_RST);
      end else if (reg_wr) begin
         if (reg_addr == OFS_CTRL)  active   <= reg_wdata[0];
         if (reg_addr == OFS_OADDR) own_addr <= reg_wdata[ADDR_W-1:0];
      end
   end

   assign rd_data = reg_rd && (reg_addr == OFS_DATA);
   assign wr_data = reg_wr && (reg_addr == OFS_DATA);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_CTRL: begin
            reg_rdata[STAT_RX_BIT]    = rreq;
            reg_rdata[STAT_TX_BIT]    = treq;
            reg_rdata[STAT_FIRST_BIT] = fbr;
         end
         OFS_DATA:  reg_rdata[BYTE_W-1:0] = rx_byte;
         OFS_OADDR: reg_rdata[ADDR_W-1:0] = own_addr;
         default: ;
      endcase
   end

   i2cs_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (line_s)
   );

   i2cs_cond_det u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (line_s[1]),
      .sda_s     (line_s[0]),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .bus_start (bus_start),
      .bus_stop  (bus_stop)
   );

   i2cs_engine #(.ADDR_W(ADDR_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .own_addr  (own_addr),
      .sda_s     (line_s[0]),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .bus_start (bus_start),
      .bus_stop  (bus_stop),
      .rd_data   (rd_data),
      .wr_data   (wr_data),
      .tx_byte   (reg_wdata[BYTE_W-1:0]),
      .rx_byte   (rx_byte),
      .rreq      (rreq),
      .treq      (treq),
      .fbr       (fbr),
      .scl_oe    (scl_oe),
      .sda_oe    (sda_oe)
   );

endmodule

// File: tb/i2c_stretch_slave_tb.sv
module i2c_stretch_slave_tb;

   localparam int         HP  = 10;
   localparam logic [6:0] OWN = 7'h3C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        m_scl = 1'b1, m_sda = 1'b1;
   logic        scl_oe, sda_oe;
   logic        scl_line, sda_line;
   int          tests = 0, fails = 0;
   bit          done = 1'b0;

   assign scl_line = m_scl & ~scl_oe;
   assign sda_line = m_sda & ~sda_oe;

   always #10 clk = ~clk;

   i2c_stretch_slave u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_scl_high();
      while (!scl_line) @(negedge clk);
   endtask

   task automatic clk_bit(input logic b, output logic s);
      m_sda = b; cyc(HP);
      m_scl = 1'b1; wait_scl_high(); cyc(HP/2);
      s = sda_line; cyc(HP/2);
      m_scl = 1'b0; cyc(HP);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; cyc(HP);
      m_scl = 1'b1; wait_scl_high(); cyc(HP);
      m_sda = 1'b0; cyc(HP);
      m_scl = 1'b0; cyc(HP);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; cyc(HP);
      m_scl = 1'b1; wait_scl_high(); cyc(HP);
      m_sda = 1'b1; cyc(HP);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      logic s;
      for (int i = 7; i > 7 - n; i--) clk_bit(b[i], s);
   endtask

   task automatic addr_phase(input logic [6:0] a, input logic rw, output logic acked);
      logic s;
      send_bits({a, rw}, 8);
      clk_bit(1'b1, s);
      acked = ~s;
   endtask

   // Master writes one data byte, software services it while SCL is stretched
   task automatic rx_byte_chk(input logic [7:0] d, input logic first);
      logic [31:0] st, v;
      logic s;
      send_bits(d, 8);
      reg_read(2'd0, st);
      chk("R4 receive request after byte", st[0], 1'b1);
      chk("R6 first-byte flag", st[2], first);
      chk("R2 status word layout", st, {29'd0, first, 1'b0, 1'b1});
      m_sda = 1'b1; m_scl = 1'b1; cyc(20);
      chk("R5 SCL held low while unread", scl_line, 1'b0);
      reg_read(2'd1, v);
      chk("R4 received byte", v, {24'd0, d});
      reg_read(2'd0, st);
      chk("R5 read clears status", st, 32'd0);
      wait_scl_high(); cyc(HP/2);
      s = sda_line;
      chk("R4 slave ACK of data", s, 1'b0);
      cyc(HP/2); m_scl = 1'b0; cyc(HP);
   endtask

   // Software supplies a byte while SCL is stretched, master clocks it out
   task automatic tx_byte_get(input logic [7:0] d, output logic [7:0] got);
      logic [31:0] st;
      logic s;
      m_sda = 1'b1; m_scl = 1'b1; cyc(20);
      chk("R7 SCL held low until data written", scl_line, 1'b0);
      reg_read(2'd0, st);
      chk("R9 transmit request without first-byte flag", st, 32'h2);
      reg_write(2'd1, {24'd0, d});
      wait_scl_high(); cyc(HP/2);
      got[7] = sda_line;
      cyc(HP/2); m_scl = 1'b0; cyc(HP);
      for (int i = 6; i >= 0; i--) begin
         clk_bit(1'b1, s);
         got[i] = s;
      end
   endtask

   task automatic master_ack(input logic nack);
      logic [31:0] st;
      logic s;
      clk_bit(nack, s);
      reg_read(2'd0, st);
      if (nack) begin
         chk("R8 NACK leaves transmit request clear", st, 32'd0);
         chk("R8 SDA released after NACK", sda_oe, 1'b0);
      end else begin
         chk("R8 ACK re-raises transmit request", st, 32'h2);
      end
   endtask

   initial begin
      logic [31:0] st;
      logic        acked;
      logic [7:0]  got;
      logic        s;
      int unsigned r;
      r = $urandom(32'd20240611);

      cyc(5);
      rst_n = 1'b1;
      cyc(2);
      // R1 reset state
      reg_read(2'd0, st);
      chk("R1 status after reset", st, 32'd0);
      chk("R1 scl_oe after reset", scl_oe, 1'b0);
      chk("R1 sda_oe after reset", sda_oe, 1'b0);
      reg_read(2'd2, st);
      chk("R1 own address reset value", st, 32'h2A);

      reg_write(2'd2, {25'd0, OWN});
      reg_read(2'd2, st);
      chk("R2 own address readback", st, {25'd0, OWN});
      reg_write(2'd0, 32'd1);

      // R12: data access with nothing pending
      reg_read(2'd1, st);
      reg_write(2'd1, 32'hAA);
      cyc(2);
      reg_read(2'd0, st);
      chk("R12 idle data access leaves status", st, 32'd0);
      chk("R12 idle write drives no SDA", sda_oe, 1'b0);
      chk("R12 idle write drives no SCL", scl_oe, 1'b0);

      // Directed write transfer
      bus_start();
      addr_phase(OWN, 1'b0, acked);
      chk("R3 address match ACK", acked, 1'b1);
      rx_byte_chk(8'hA5, 1'b1);
      rx_byte_chk(8'h00, 1'b0);
      rx_byte_chk(8'hFF, 1'b0);
      bus_stop();

      // Mismatch, then a byte equal to the own address must still be ignored
      bus_start();
      addr_phase(OWN ^ 7'h01, 1'b0, acked);
      chk("R3 mismatched address not ACKed", acked, 1'b0);
      addr_phase(OWN, 1'b0, acked);
      chk("R3 ignored until START", acked, 1'b0);
      reg_read(2'd0, st);
      chk("R3 no flag while ignored", st, 32'd0);
      bus_stop();

      // Directed read transfer
      bus_start();
      addr_phase(OWN, 1'b1, acked);
      chk("R7 read address ACK", acked, 1'b1);
      tx_byte_get(8'hC3, got);
      chk("R7 transmitted byte", got, 8'hC3);
      master_ack(1'b0);
      tx_byte_get(8'h3E, got);
      chk("R7 second transmitted byte", got, 8'h3E);
      master_ack(1'b1);
      clk_bit(1'b1, s);
      chk("R8 SDA stays high after NACK", s, 1'b1);
      bus_stop();

      // R10: repeated START mid-byte turns a write into a read
      bus_start();
      addr_phase(OWN, 1'b0, acked);
      send_bits(8'h5A, 4);
      bus_start();
      addr_phase(OWN, 1'b1, acked);
      chk("R10 repeated START re-addresses", acked, 1'b1);
      tx_byte_get(8'h81, got);
      chk("R10 byte after repeated START", got, 8'h81);
      master_ack(1'b1);
      bus_stop();

      // R10: STOP mid-byte, then the next transfer flags its first byte again
      bus_start();
      addr_phase(OWN, 1'b0, acked);
      rx_byte_chk(8'h11, 1'b1);
      send_bits(8'hE0, 3);
      bus_stop();
      bus_start();
      addr_phase(OWN, 1'b0, acked);
      chk("R10 ACK after STOP", acked, 1'b1);
      rx_byte_chk(8'h22, 1'b1);
      bus_stop();

      // Random transfers
      for (int t = 0; t < 8; t++) begin
         logic       match, rw;
         logic [6:0] a;
         int         n;
         match = ($urandom % 10) < 7;
         rw    = $urandom % 2;
         n     = 1 + ($urandom % 3);
         a     = match ? OWN : (OWN ^ 7'(1 + ($urandom % 127)));
         bus_start();
         addr_phase(a, rw, acked);
         chk("R3 random address decision", acked, match);
         if (!match) begin
            send_bits(8'(($urandom)), 8);
            clk_bit(1'b1, s);
            chk("R3 random ignored byte not ACKed", s, 1'b1);
            reg_read(2'd0, st);
            chk("R3 random ignored status", st, 32'd0);
         end else if (!rw) begin
            for (int k = 0; k < n; k++) rx_byte_chk(8'($urandom), k == 0);
         end else begin
            for (int k = 0; k < n; k++) begin
               logic [7:0] d;
               d = 8'($urandom);
               tx_byte_get(d, got);
               chk("R7 random transmitted byte", got, d);
               master_ack(k == n - 1);
            end
         end
         bus_stop();
      end

      // R11: disable while a byte is pending
      bus_start();
      addr_phase(OWN, 1'b0, acked);
      send_bits(8'h66, 8);
      reg_read(2'd0, st);
      chk("R11 pending before disable", st, 32'h5);
      reg_write(2'd0, 32'd0);
      cyc(2);
      chk("R11 SCL released on disable", scl_oe, 1'b0);
      chk("R11 SDA released on disable", sda_oe, 1'b0);
      reg_read(2'd0, st);
      chk("R11 flags cleared on disable", st, 32'd0);
      bus_stop();
      bus_start();
      addr_phase(OWN, 1'b0, acked);
      chk("R11 no ACK while disabled", acked, 1'b0);
      bus_stop();
      reg_write(2'd0, 32'd1);
      bus_start();
      addr_phase(OWN, 1'b0, acked);
      chk("R11 ACK after re-enable", acked, 1'b1);
      rx_byte_chk(8'h99, 1'b1);
      bus_stop();

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule